// File: doc/BRIEF.md
# Tagged Transmit Byte Queue

This block is the staging queue between a host and a serial frame transmitter. The host pushes bytes one per cycle. Each byte is stored together with two sideband tags. One tag marks the last byte of a packet and the other asks the transmitter to abort the frame. The tags are sampled from the host's control inputs in the same cycle as the byte.

On the other side, the transmitter raises a load request whenever its output shifter has room. The oldest stored entry is then copied into the shifter register, with its tags, and every remaining entry moves one place toward the head. The queue holds nineteen entries.

A write that arrives while the queue is full is not lost. It replaces the newest entry, and the occupancy does not change. A load request that finds the queue empty changes nothing except raising a one-cycle underrun strobe.

Top module: `txq_tagged`

## Requirements
- R1: While `rst_n` is low, and after its release, the queue is empty: `level` = 0, `empty` = 1, `full` = 0, `load_valid` = 0, `underrun` = 0. Asserting `rst_n` low clears the queue at once, whatever it held before.
- R2: Bytes leave in the order they were written. For a `load_req` on a non-empty queue, `load_valid` is 1 on the following cycle, and `load_data` shows the oldest byte from that edge on. `load_data` holds its value until the next successful load.
- R3: The `wr_eop` and `wr_abort` values present in the write cycle are stored with the byte. They appear on `load_eop` and `load_abort` together with that byte.
- R4: `level` reports 0 to 19 stored entries. `full` is 1 exactly when `level` is 19, and `empty` is 1 exactly when `level` is 0.
- R5: A write to a full queue with no `load_req` replaces the most recently written entry (byte and tags), leaves `level` at 19, and leaves all older entries untouched.
- R6: A `load_req` on an empty queue leaves `level` and the shifter outputs (`load_data`, `load_eop`, `load_abort`) unchanged. It keeps `load_valid` at 0 and raises `underrun` for exactly the next cycle.
- R7: A write together with a `load_req` on a full queue first pops the oldest entry and then appends the new byte as the newest entry. `level` stays 19.
- R8: A write together with a `load_req` on a queue holding 1 to 18 entries pops the oldest entry, appends the new byte, and leaves `level` unchanged.
- R9: A write together with a `load_req` on an empty queue stores the byte, giving `level` = 1, and raises `underrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to queue |
| wr_eop | input | 1 | End-of-packet tag sampled with the byte |
| wr_abort | input | 1 | Frame-abort tag sampled with the byte |
| load_req | input | 1 | Transmitter request to load the shifter |
| full | output | 1 | Queue holds 19 entries |
| empty | output | 1 | Queue holds no entry |
| level | output | 5 | Number of stored entries |
| load_data | output | 8 | Shifter register byte |
| load_eop | output | 1 | End-of-packet tag of the shifter byte |
| load_abort | output | 1 | Frame-abort tag of the shifter byte |
| load_valid | output | 1 | One-cycle pulse: shifter loaded on the previous edge |
| underrun | output | 1 | One-cycle pulse: load requested on an empty queue |

## Verification
The assertions take `wr_en` and `load_req` to be known 0/1 values at every rising edge once the internal reset has released. They also take a request to act in the cycle it is sampled, with no handshake to hold it. The bench meets this by changing inputs only one nanosecond after a rising edge. It holds each strobe for exactly one edge and waits out the two-cycle reset release before its first stimulus. The vector walk and the directed tests reach every occupancy case that the pop and append rules separate: empty, partly filled, and full, each with and without a simultaneous write.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              eop;
    logic              abort;
    logic [BYTE_W-1:0] data;
  } txq_entry_t;
endpackage

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int unsigned DEPTH = 19,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             load_req,
  output logic             pop,
  output logic             wr_go,
  output logic [IDX_W-1:0] wr_idx,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, after_pop;
  logic             cnt_en;

  always_comb begin
    pop       = load_req && (cnt_q != '0);
    after_pop = cnt_q - CNT_W'(pop);
    wr_go     = wr_en;
    if (after_pop == CNT_MAX) begin
      wr_idx = IDX_TOP;
      cnt_d  = after_pop;
    end else begin
      wr_idx = after_pop[IDX_W-1:0];
      cnt_d  = after_pop + CNT_W'(wr_en);
    end
    cnt_en = pop || wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign level = cnt_q;
  assign full  = (cnt_q == CNT_MAX);
  assign empty = (cnt_q == '0);

  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  p_pop_lowers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !empty && !wr_en) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_overwrite_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !load_req) |=> (full && $stable(cnt_q)));
  p_swap_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && wr_en && load_req) |=> $stable(cnt_q));
endmodule

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 19,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             pop,
  input  logic             wr_go,
  input  logic [IDX_W-1:0] wr_idx,
  input  txq_entry_t       wr_entry,
  output txq_entry_t       head
);
  txq_entry_t slot_q [DEPTH];
  txq_entry_t slot_d [DEPTH];
  logic       slot_en [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit;
    assign hit = wr_go && (wr_idx == IDX_W'(i));

    if (i < DEPTH - 1) begin : g_mid
      always_comb begin
        slot_d[i] = hit ? wr_entry : slot_q[i+1];
      end
    end else begin : g_top
      always_comb begin
        slot_d[i] = hit ? wr_entry : slot_q[i];
      end
    end

    assign slot_en[i] = pop || hit;

    always_ff @(posedge clk) begin
      if (slot_en[i]) slot_q[i] <= slot_d[i];
    end
  end

  assign head = slot_q[0];
endmodule

// File: rtl/txq_out.sv
module txq_out
  import txq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pop,
  input  logic       load_req,
  input  logic       empty,
  input  txq_entry_t head,
  output txq_entry_t shifter,
  output logic       load_valid,
  output logic       underrun
);
  txq_entry_t sh_q;
  logic       vld_q, und_q, und_d;

  always_comb begin
    und_d = load_req && empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sh_q <= '0;
    else if (pop) sh_q <= head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      vld_q <= pop;
      und_q <= und_d;
    end
  end

  assign shifter    = sh_q;
  assign load_valid = vld_q;
  assign underrun   = und_q;

  p_underrun_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && empty) |=> (underrun && !load_valid && $stable(sh_q)));
  p_load_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !empty) |=> (load_valid && !underrun));
  p_shifter_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |-> $stable(sh_q));
endmodule

// File: rtl/txq_tagged.sv
module txq_tagged
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 19,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_eop,
  input  logic              wr_abort,
  input  logic              load_req,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  level,
  output logic [BYTE_W-1:0] load_data,
  output logic              load_eop,
  output logic              load_abort,
  output logic              load_valid,
  output logic              underrun
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             pop, wr_go;
  logic [IDX_W-1:0] wr_idx;
  txq_entry_t       wr_entry, head, shifter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    wr_entry.eop   = wr_eop;
    wr_entry.abort = wr_abort;
    wr_entry.data  = wr_data;
  end

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .load_req(load_req),
    .pop(pop), .wr_go(wr_go), .wr_idx(wr_idx), .level(level),
    .full(full), .empty(empty)
  );

  txq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .pop(pop), .wr_go(wr_go), .wr_idx(wr_idx),
    .wr_entry(wr_entry), .head(head)
  );

  txq_out u_out (
    .clk(clk), .rst_n(rst_int_n), .pop(pop), .load_req(load_req),
    .empty(empty), .head(head), .shifter(shifter),
    .load_valid(load_valid), .underrun(underrun)
  );

  assign load_data  = shifter.data;
  assign load_eop   = shifter.eop;
  assign load_abort = shifter.abort;

  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(full && empty));
  p_swap_full_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (full && wr_en && load_req) |=> (full && load_valid));
  p_empty_write_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (empty && wr_en && load_req) |=> (level == 1 && underrun));
endmodule

// File: tb/tb_txq_tagged.sv
`timescale 1ns/1ps
module tb_txq_tagged;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_eop = 1'b0, wr_abort = 1'b0, load_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       full, empty, load_eop, load_abort, load_valid, underrun;
  logic [4:0] level;
  logic [7:0] load_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  txq_tagged dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_eop(wr_eop), .wr_abort(wr_abort), .load_req(load_req),
    .full(full), .empty(empty), .level(level), .load_data(load_data),
    .load_eop(load_eop), .load_abort(load_abort),
    .load_valid(load_valid), .underrun(underrun)
  );

  // fields: wr ld din[8] eop ab | level[5] valid data[8] eop ab und
  localparam int NV = 9;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1,1'b0,8'hA1,1'b0,1'b0, 5'd1,1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b1,1'b0,8'hB2,1'b1,1'b0, 5'd2,1'b0,8'h00,1'b0,1'b0,1'b0},
    {1'b0,1'b1,8'h00,1'b0,1'b0, 5'd1,1'b1,8'hA1,1'b0,1'b0,1'b0},
    {1'b1,1'b1,8'hC3,1'b0,1'b1, 5'd1,1'b1,8'hB2,1'b1,1'b0,1'b0},
    {1'b0,1'b1,8'h00,1'b0,1'b0, 5'd0,1'b1,8'hC3,1'b0,1'b1,1'b0},
    {1'b0,1'b1,8'h00,1'b0,1'b0, 5'd0,1'b0,8'hC3,1'b0,1'b1,1'b1},
    {1'b1,1'b1,8'hD4,1'b0,1'b0, 5'd1,1'b0,8'hC3,1'b0,1'b1,1'b1},
    {1'b0,1'b0,8'h00,1'b0,1'b0, 5'd1,1'b0,8'hC3,1'b0,1'b1,1'b0},
    {1'b0,1'b1,8'h00,1'b0,1'b0, 5'd0,1'b1,8'hD4,1'b0,1'b0,1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic l, input logic [7:0] d,
                      input logic e, input logic a);
    wr_en = w; load_req = l; wr_data = d; wr_eop = e; wr_abort = a;
    @(posedge clk); #1;
    wr_en = 0; load_req = 0; wr_data = 8'h00; wr_eop = 0; wr_abort = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 valid", load_valid, 0);
    chk("R1 underrun", underrun, 0);

    // vector walk: R2 R3 R6 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      step(v[28], v[27], v[26:19], v[18], v[17]);
      chk($sformatf("R2/R8 level vec%0d", i), level, v[16:12]);
      chk($sformatf("R2 valid vec%0d", i), load_valid, v[11]);
      chk($sformatf("R2 data vec%0d", i), load_data, v[10:3]);
      chk($sformatf("R3 tags vec%0d", i), {load_eop, load_abort}, v[2:1]);
      chk($sformatf("R6/R9 underrun vec%0d", i), underrun, v[0]);
    end

    // R4 fill to capacity
    for (int i = 0; i < 19; i++) begin
      step(1, 0, 8'h10 + 8'(i), (i == 18), 0);
      chk("R4 not full early", full, (i == 18));
    end
    chk("R4 level 19", level, 19);
    chk("R4 empty", empty, 0);

    // R5 overwrite newest
    step(1, 0, 8'hEE, 0, 1);
    chk("R5 level kept", level, 19);
    chk("R5 full kept", full, 1);

    // R7 pop then append on full
    step(1, 1, 8'h77, 1, 0);
    chk("R7 level", level, 19);
    chk("R7 popped data", load_data, 8'h10);
    chk("R7 valid", load_valid, 1);

    // drain: older entries untouched (R5), order (R2), tags (R3)
    for (int i = 0; i < 17; i++) begin
      step(0, 1, 8'h00, 0, 0);
      chk("R5 older data", load_data, 8'h11 + 8'(i));
      chk("R3 older tags", {load_eop, load_abort}, 2'b00);
    end
    step(0, 1, 8'h00, 0, 0);
    chk("R5 replaced data", load_data, 8'hEE);
    chk("R5 replaced tags", {load_eop, load_abort}, 2'b01);
    step(0, 1, 8'h00, 0, 0);
    chk("R7 appended data", load_data, 8'h77);
    chk("R7 appended tags", {load_eop, load_abort}, 2'b10);
    chk("R4 empty after drain", empty, 1);
    chk("R4 level after drain", level, 0);

    // R1 asynchronous clear mid-operation
    step(1, 0, 8'h55, 0, 0);
    step(1, 0, 8'h66, 0, 0);
    chk("R1 pre-reset level", level, 2);
    rst_n = 0;
    #1;
    chk("R1 async level", level, 0);
    chk("R1 async empty", empty, 1);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 post-release level", level, 0);
    chk("R1 post-release data", load_data, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule